// File: doc/BRIEF.md
# Two-Bank Interrupt Controller

This block collects up to 64 active-high interrupt requests. Each source sits in one of two banks of 32. Every bank holds a per-source enable word and a per-source steering word. An enabled source reaches either the normal processor interrupt line or the fast processor interrupt line, and the steering bit picks which one. Masked sources take no part in either line. Software can still see them in a live raw-status word.

Both processor lines are registered. For each line, an encoded index word names the lowest-numbered source that is driving it. Interrupt service code can read that word to find a source without scanning the status bits. The upper bank is present only when the `NUM_BANKS` parameter is 2. With one bank, requests 32 to 63 have no effect and the upper-bank addresses read as zero. All access goes through a simple 32-bit port: a write strobe, a word address and a combinational read word.

The port has eight words. Bits [2:0] of the address select them:
- 0 and 3: lower and upper raw status (read only).
- 1 and 4: lower and upper enable.
- 2 and 5: lower and upper steering.
- 6: normal-line index (read only).
- 7: fast-line index (read only).

Top module: `icb_top`

## Requirements
- R1: After reset, every enable and steering bit is 0. Both interrupt outputs are low, and both index words read 32'h8000_0000.
- R2: Enable bit n set to 1 lets source n through. Cleared to 0, source n drives neither output, even while its request is high.
- R3: For an enabled source, steering bit 0 sends it to `irq_norm_o` only, and steering bit 1 sends it to `irq_fast_o` only.
- R4: Raw status words (address 0 for sources 0-31, address 3 for sources 32-63) return the live request inputs, whatever the enable state.
- R5: Each interrupt output changes exactly one clock edge after the request or register change that causes it.
- R6: The index word for an output (address 6 normal, 7 fast) reads {1'b0, 25'b0, n[5:0]}, where n is the lowest-numbered source currently driving that output. It reads 32'h8000_0000 when nothing drives that output.
- R7: The upper bank's enable (address 4) and steering (address 5) control sources 32-63 bit for bit, independently of the lower bank.
- R8: With `NUM_BANKS` = 1, requests 32-63 never affect the outputs or index words. Addresses 3, 4 and 5 read 0, and writes to them are dropped.
- R9: Enable and steering words read back what was last written. Writes to the raw-status or index addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Interrupt requests, bit n is source n, active high |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Word address of the register port |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_norm_o | output | 1 | Registered normal interrupt line |
| irq_fast_o | output | 1 | Registered fast interrupt line |

## Verification
The bench drives several sources at once with mixed steering. A design with a mis-ordered encoder would then report a higher index than the lowest one, and a design that inverts steering would light the wrong line. Source 63 and source 0 are exercised at the edges of the index range. Every source asserted with every source masked catches a design that leaks masked requests. An instance with one bank runs beside the two-bank one on the same stimulus. A single-bank build that still honours upper requests would raise its line and report index 40 where the two-bank instance legitimately does. One test observes the cycle just before and just after a request edge, which catches an output that lacks the register or has one stage too many.

// File: rtl/icb_pkg.sv
package icb_pkg;
    localparam int DATA_W   = 32;
    localparam int BANK_W   = 32;
    localparam int MAX_SRC  = 2 * BANK_W;
    localparam int IDX_W    = $clog2(MAX_SRC);
    localparam int ADDR_W   = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_RAW_LO  = 3'd0,
        SEL_EN_LO   = 3'd1,
        SEL_RT_LO   = 3'd2,
        SEL_RAW_HI  = 3'd3,
        SEL_EN_HI   = 3'd4,
        SEL_RT_HI   = 3'd5,
        SEL_IDX_NRM = 3'd6,
        SEL_IDX_FST = 3'd7
    } reg_sel_e;

    function automatic logic [DATA_W-1:0] pack_index(input logic none,
                                                     input logic [IDX_W-1:0] idx);
        return {none, {(DATA_W-1-IDX_W){1'b0}}, (none ? {IDX_W{1'b0}} : idx)};
    endfunction
endpackage

// File: rtl/icb_bank.sv
module icb_bank #(
    parameter int W       = 32,
    parameter bit PRESENT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_en,
    input  logic         we_rt,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] src,
    output logic [W-1:0] en_q,
    output logic [W-1:0] rt_q,
    output logic [W-1:0] pend_n_q,
    output logic [W-1:0] pend_f_q
);
    generate
        if (PRESENT) begin : g_live
            logic [W-1:0] live;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    en_q <= '0;
                    rt_q <= '0;
                end else begin
                    if (we_en) en_q <= wdata;
                    if (we_rt) rt_q <= wdata;
                end
            end

            assign live = src & en_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pend_n_q <= '0;
                    pend_f_q <= '0;
                end else begin
                    pend_n_q <= live & ~rt_q;
                    pend_f_q <= live &  rt_q;
                end
            end
        end else begin : g_absent
            logic unused_bank;
            assign unused_bank = ^{clk, rst_n, we_en, we_rt, wdata, src};
            assign en_q     = '0;
            assign rt_q     = '0;
            assign pend_n_q = '0;
            assign pend_f_q = '0;
        end
    endgenerate
endmodule

// File: rtl/icb_lowest.sv
module icb_lowest #(
    parameter int W  = 64,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          none
);
    always_comb begin
        idx  = '0;
        none = 1'b1;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx  = IW'(i);
                none = 1'b0;
            end
        end
    end
endmodule

// File: rtl/icb_top.sv
module icb_top #(
    parameter int NUM_BANKS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [icb_pkg::MAX_SRC-1:0] src_i,
    input  logic                        reg_we,
    input  logic [icb_pkg::ADDR_W-1:0]  reg_addr,
    input  logic [icb_pkg::DATA_W-1:0]  reg_wdata,
    output logic [icb_pkg::DATA_W-1:0]  reg_rdata,
    output logic                        irq_norm_o,
    output logic                        irq_fast_o
);
    import icb_pkg::*;

    localparam bit HAS_HI = (NUM_BANKS > 1);

    reg_sel_e           sel;
    logic [BANK_W-1:0]  en_w   [2];
    logic [BANK_W-1:0]  rt_w   [2];
    logic [BANK_W-1:0]  pn_w   [2];
    logic [BANK_W-1:0]  pf_w   [2];
    logic [MAX_SRC-1:0] pend_n_all;
    logic [MAX_SRC-1:0] pend_f_all;
    logic [MAX_SRC-1:0] en_all;
    logic [IDX_W-1:0]   idx_n;
    logic [IDX_W-1:0]   idx_f;
    logic               none_n;
    logic               none_f;
    logic [DATA_W-1:0]  idx_word_n;
    logic [DATA_W-1:0]  idx_word_f;
    logic [DATA_W-1:0]  raw_hi;

    assign sel = reg_sel_e'(reg_addr);

    generate
        for (genvar b = 0; b < 2; b++) begin : g_bank
            localparam bit PRES = (b == 0) ? 1'b1 : HAS_HI;
            localparam reg_sel_e EN_SEL = (b == 0) ? SEL_EN_LO : SEL_EN_HI;
            localparam reg_sel_e RT_SEL = (b == 0) ? SEL_RT_LO : SEL_RT_HI;

            icb_bank #(.W(BANK_W), .PRESENT(PRES)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .we_en    (reg_we && (sel == EN_SEL)),
                .we_rt    (reg_we && (sel == RT_SEL)),
                .wdata    (reg_wdata),
                .src      (src_i[b*BANK_W +: BANK_W]),
                .en_q     (en_w[b]),
                .rt_q     (rt_w[b]),
                .pend_n_q (pn_w[b]),
                .pend_f_q (pf_w[b])
            );
        end
    endgenerate

    assign pend_n_all = {pn_w[1], pn_w[0]};
    assign pend_f_all = {pf_w[1], pf_w[0]};
    assign en_all     = {en_w[1], en_w[0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_norm_o <= 1'b0;
            irq_fast_o <= 1'b0;
        end else begin
            irq_norm_o <= |({src_i[MAX_SRC-1:BANK_W] & en_w[1] & ~rt_w[1],
                             src_i[BANK_W-1:0]       & en_w[0] & ~rt_w[0]});
            irq_fast_o <= |({src_i[MAX_SRC-1:BANK_W] & en_w[1] &  rt_w[1],
                             src_i[BANK_W-1:0]       & en_w[0] &  rt_w[0]});
        end
    end

    icb_lowest #(.W(MAX_SRC), .IW(IDX_W)) u_low_n (
        .vec  (pend_n_all),
        .idx  (idx_n),
        .none (none_n)
    );

    icb_lowest #(.W(MAX_SRC), .IW(IDX_W)) u_low_f (
        .vec  (pend_f_all),
        .idx  (idx_f),
        .none (none_f)
    );

    assign idx_word_n = pack_index(none_n, idx_n);
    assign idx_word_f = pack_index(none_f, idx_f);
    assign raw_hi     = HAS_HI ? src_i[MAX_SRC-1:BANK_W] : '0;

    always_comb begin
        unique case (sel)
            SEL_RAW_LO:  reg_rdata = src_i[BANK_W-1:0];
            SEL_EN_LO:   reg_rdata = en_w[0];
            SEL_RT_LO:   reg_rdata = rt_w[0];
            SEL_RAW_HI:  reg_rdata = raw_hi;
            SEL_EN_HI:   reg_rdata = en_w[1];
            SEL_RT_HI:   reg_rdata = rt_w[1];
            SEL_IDX_NRM: reg_rdata = idx_word_n;
            SEL_IDX_FST: reg_rdata = idx_word_f;
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/icb_chk.sv
module icb_chk #(
    parameter int NUM_BANKS = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        irq_norm_o,
    input logic        irq_fast_o,
    input logic [31:0] idx_word_n,
    input logic [31:0] idx_word_f,
    input logic [63:0] en_all
);
    a_r1_reset_clear: assert property (@(posedge clk)
        (!rst_n) |=> (!irq_norm_o && !irq_fast_o && en_all == 64'd0));

    a_r2_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (en_all == 64'd0) |=> (!irq_norm_o && !irq_fast_o));

    a_r6_norm_index_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        irq_norm_o == !idx_word_n[31]);

    a_r6_fast_index_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast_o == !idx_word_f[31]);

    a_r6_index_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_word_n[30:6] == 25'd0) && (idx_word_f[30:6] == 25'd0));

    a_r3_one_line_per_source: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_word_n[31] && !idx_word_f[31]) |-> (idx_word_n[5:0] != idx_word_f[5:0]));

    a_r8_no_upper_index: assert property (@(posedge clk) disable iff (!rst_n)
        (NUM_BANKS == 1) |-> ((idx_word_n[31] || !idx_word_n[5]) &&
                              (idx_word_f[31] || !idx_word_f[5])));
endmodule

bind icb_top icb_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_norm_o (irq_norm_o),
    .irq_fast_o (irq_fast_o),
    .idx_word_n (idx_word_n),
    .idx_word_f (idx_word_f),
    .en_all     (en_all)
);

// File: tb/tb_icb_top.sv
module tb_icb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_i = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, rdata1;
    logic        irq_norm_o, irq_fast_o, irqn1, irqf1;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    icb_top #(.NUM_BANKS(2)) dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_norm_o(irq_norm_o), .irq_fast_o(irq_fast_o)
    );

    icb_top #(.NUM_BANKS(1)) dut_single (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata1),
        .irq_norm_o(irqn1), .irq_fast_o(irqf1)
    );

    typedef struct packed {
        logic [63:0] src;
        logic [31:0] en_lo;
        logic [31:0] rt_lo;
        logic [31:0] en_hi;
        logic [31:0] rt_hi;
        logic        exp_n;
        logic        exp_f;
        logic [31:0] exp_in;
        logic [31:0] exp_if;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{64'h1, 32'h1, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 32'h0, 32'h8000_0000},
        '{64'h1, 32'h1, 32'h1, 32'h0, 32'h0, 1'b0, 1'b1, 32'h8000_0000, 32'h0},
        '{64'hF0, 32'hA0, 32'h80, 32'h0, 32'h0, 1'b1, 1'b1, 32'd5, 32'd7},
        '{64'h8000_0000_0000_0000, 32'h0, 32'h0, 32'h8000_0000, 32'h0,
          1'b1, 1'b0, 32'd63, 32'h8000_0000},
        '{64'hFFFF_FFFF_FFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h0,
          1'b0, 1'b0, 32'h8000_0000, 32'h8000_0000},
        '{64'h0000_0010_0000_0002, 32'h3, 32'h2, 32'h10, 32'h10,
          1'b0, 1'b1, 32'h8000_0000, 32'd1},
        '{64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h0,
          1'b1, 1'b1, 32'd0, 32'd1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd1(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = rdata1;
    endtask

    initial begin
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq_norm", irq_norm_o, 1'b0);
        chk("R1 irq_fast", irq_fast_o, 1'b0);
        for (int a = 1; a < 6; a++) begin
            if (a != 3) begin
                rd(3'(a), d);
                chk("R1 cfg word zero", d, 32'h0);
            end
        end
        rd(3'd6, d); chk("R1 norm index empty", d, 32'h8000_0000);
        rd(3'd7, d); chk("R1 fast index empty", d, 32'h8000_0000);

        // table walk: R2 R3 R6 R7
        for (int v = 0; v < NV; v++) begin
            wr(3'd1, VEC[v].en_lo);
            wr(3'd2, VEC[v].rt_lo);
            wr(3'd4, VEC[v].en_hi);
            wr(3'd5, VEC[v].rt_hi);
            src_i = VEC[v].src;
            @(negedge clk);
            @(negedge clk);
            chk($sformatf("R2/R3 vec%0d normal line", v), irq_norm_o, VEC[v].exp_n);
            chk($sformatf("R2/R3 vec%0d fast line", v), irq_fast_o, VEC[v].exp_f);
            rd(3'd6, d); chk($sformatf("R6 vec%0d norm index", v), d, VEC[v].exp_in);
            rd(3'd7, d); chk($sformatf("R6 R7 vec%0d fast index", v), d, VEC[v].exp_if);
        end

        // R9 readback and read-only writes
        wr(3'd1, 32'h1234_5678);
        wr(3'd5, 32'hCAFE_0001);
        rd(3'd1, d); chk("R9 enable readback", d, 32'h1234_5678);
        rd(3'd5, d); chk("R9 steering readback", d, 32'hCAFE_0001);
        src_i = 64'h0000_0000_0000_00A5;
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd6, 32'h0000_0003);
        rd(3'd0, d); chk("R9 raw write dropped", d, 32'h0000_00A5);
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h0);
        wr(3'd4, 32'h0);
        wr(3'd5, 32'h0);
        @(negedge clk);
        rd(3'd6, d); chk("R9 index write dropped", d, 32'h8000_0000);

        // R4 raw status with everything masked
        src_i = 64'h8765_4321_0F0F_F0F0;
        #1;
        rd(3'd0, d); chk("R4 raw lower", d, 32'h0F0F_F0F0);
        rd(3'd3, d); chk("R4 raw upper", d, 32'h8765_4321);
        @(negedge clk);
        chk("R2 masked sources silent", {irq_norm_o, irq_fast_o}, 2'b00);

        // R5 one-edge latency
        src_i = '0;
        wr(3'd1, 32'h0000_0100);
        @(negedge clk);
        chk("R5 idle before edge", irq_norm_o, 1'b0);
        src_i[8] = 1'b1;
        #1;
        chk("R5 no combinational path", irq_norm_o, 1'b0);
        @(negedge clk);
        chk("R5 set after one edge", irq_norm_o, 1'b1);
        src_i[8] = 1'b0;
        #1;
        chk("R5 held until edge", irq_norm_o, 1'b1);
        @(negedge clk);
        chk("R5 clear after one edge", irq_norm_o, 1'b0);

        // R8 single-bank build ignores upper sources
        wr(3'd1, 32'h0);
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd5, 32'h0);
        src_i = 64'h0000_0100_0000_0000;
        @(negedge clk);
        @(negedge clk);
        chk("R7 two-bank upper source", irq_norm_o, 1'b1);
        rd(3'd6, d); chk("R7 two-bank index 40", d, 32'd40);
        chk("R8 single-bank line low", {irqn1, irqf1}, 2'b00);
        rd1(3'd6, d); chk("R8 single-bank index empty", d, 32'h8000_0000);
        rd1(3'd4, d); chk("R8 single-bank upper enable reads 0", d, 32'h0);
        rd1(3'd3, d); chk("R8 single-bank upper raw reads 0", d, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule